// File: doc/BRIEF.md
# Fractional Root Clock Generator

This block builds one output clock from a choice of several free-running source clocks. The chosen source is first divided by a pre-divider that can divide by half-integer steps. After that, an optional fractional stage can run. Each pre-divided period this stage adds a step M to an accumulator modulo N, and it compares the accumulator against a duty threshold. The result is an output that averages M/N of the pre-divided rate, with a duty cycle that software chooses.

Software programs the block through a small register port. It writes shadow copies of the configuration word and of the M, N and D values. It then raises an update request. The block moves all shadow values into its working registers in a single cycle. It does this only when the output is low at the end of a pre-divided period, so the switch never cuts a pulse short. The request bit then drops.

The source inputs are asynchronous to the register clock. Each one is brought in through its own synchroniser. The output is a register in the register clock domain, so every source must toggle more slowly than half the register clock rate.

Top module: `root_clk_gen`

## Requirements
- R1: After reset the output is low, every register reads zero, and the generator runs from source 0 with the pre-divider bypassed.
- R2: The registers are at these addresses: 0 command, 1 config, 2 M, 3 N, 4 D. Config keeps only its low 14 bits, and its higher bits read as zero. M, N and D keep and return their low MND_W bits.
- R3: Writing the command register with bit 0 set raises the update request, and bit 0 reads back as the live request. Writing 0 to bit 0 has no effect. The request clears when the new settings are taken into use.
- R4: Writes to config, M, N or D do not change the output until an update is taken.
- R5: Config bits 10:8 select the source. An index of NSRC or above selects no clock. In that case the output stays low, and a pending update is taken at once, without waiting for a source edge.
- R6: Config bits 4:0 hold a pre-divider code c, where 0 behaves as 1. The output period is max(c,1)+1 source half-periods. The output is high for floor((max(c,1)+2)/2) of them. So c=3 divides by 2 and c=4 divides by 2.5.
- R7: Config bits 13:12 equal to 2 enable the fractional stage. Each pre-divided period, acc becomes (acc+M) mod N and the output equals (2*acc < 2D). Here N = M + ~Nreg and 2D = ~Dreg, both taken over MND_W bits. Any other mode value gives the plain pre-divided output.
- R8: An update is taken only when the output is low at the end of a pre-divided period, or when the active source is absent. The output is low right after an update, and the counters restart from zero.
- R9: With M=1, an even N, and Dreg = ~N, the output is high for N/2 pre-divided periods and low for N/2.
- R10: With M<N, the output has exactly M rising edges in every N pre-divided periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and generator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| src_clk | input | NSRC | Asynchronous source clocks |
| clk_out | output | 1 | Generated clock |

## Verification
The bench checks that shadow writes leave the running output alone. A design that applied them early would change the measured period before the update. The half-step divide code 4 must give a 25-cycle period with a 15-cycle high time. An off-by-one in the count limit or the high length would shift either number. The bench also checks the fractional stage two ways: for exact 50% duty, and for a count of two rising edges per five periods. A wrong decode of the complemented N or 2D value would break both. Switching to an absent source and back tests the escape path. A design that only commits on a source edge would leave the request stuck forever.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int CFG_W = 14;
  localparam logic [1:0] MODE_MND = 2'd2;

  typedef enum logic [2:0] {
    A_CMD = 3'd0,
    A_CFG = 3'd1,
    A_M   = 3'd2,
    A_N   = 3'd3,
    A_D   = 3'd4
  } rcg_addr_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] src;
    logic [4:0] code;
  } rcg_cfg_t;

  // last half-period index of one pre-divided period
  function automatic logic [5:0] half_max(input logic [4:0] code);
    return (code == 5'd0) ? 6'd1 : {1'b0, code};
  endfunction

  // number of half-periods the plain output stays high
  function automatic logic [5:0] high_len(input logic [5:0] cmax);
    return (cmax + 6'd2) >> 1;
  endfunction
endpackage

// File: rtl/rcg_regfile.sv
module rcg_regfile
  import rcg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MND_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  output logic [DATA_W-1:0] rdata,
  output logic              pending,
  output rcg_cfg_t          sh_cfg,
  output logic [MND_W-1:0]  sh_m,
  output logic [MND_W-1:0]  sh_n,
  output logic [MND_W-1:0]  sh_d
);
  logic [CFG_W-1:0] cfg_q;
  logic [MND_W-1:0] m_q, n_q, d_q;
  logic             pend_q;
  logic             req_set;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CFG_W];
  assign req_set = wr && (addr == A_CMD) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      m_q    <= '0;
      n_q    <= '0;
      d_q    <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr) begin
        case (addr)
          A_CFG:   cfg_q <= wdata[CFG_W-1:0];
          A_M:     m_q   <= wdata[MND_W-1:0];
          A_N:     n_q   <= wdata[MND_W-1:0];
          A_D:     d_q   <= wdata[MND_W-1:0];
          default: ;
        endcase
      end
      if (req_set)     pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CMD:   rdata[0]           = pend_q;
      A_CFG:   rdata[CFG_W-1:0]   = cfg_q;
      A_M:     rdata[MND_W-1:0]   = m_q;
      A_N:     rdata[MND_W-1:0]   = n_q;
      A_D:     rdata[MND_W-1:0]   = d_q;
      default: rdata = '0;
    endcase
  end

  assign pending = pend_q;
  assign sh_cfg  = '{mode: cfg_q[13:12], src: cfg_q[10:8], code: cfg_q[4:0]};
  assign sh_m    = m_q;
  assign sh_n    = n_q;
  assign sh_d    = d_q;

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !req_set) |=> !pend_q); // R3
  AST_ZERO_WRITE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !req_set) |=> !pend_q); // R3
endmodule

// File: rtl/rcg_src_sync.sv
module rcg_src_sync #(
  parameter int NSRC = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_clk,
  output logic [NSRC-1:0] src_edge
);
  localparam int CHAIN = STAGES + 1;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], src_clk[i]};
    end
    // any level change of the source is one half-period event
    assign src_edge[i] = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];
  end
endmodule

// File: rtl/rcg_div_core.sv
module rcg_div_core
  import rcg_pkg::*;
#(
  parameter int NSRC  = 2,
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_edge,
  input  logic             pending,
  input  rcg_cfg_t         sh_cfg,
  input  logic [MND_W-1:0] sh_m,
  input  logic [MND_W-1:0] sh_n,
  input  logic [MND_W-1:0] sh_d,
  output logic             commit,
  output logic             clk_out
);
  localparam logic [3:0] NSRC_L = 4'(NSRC);

  function automatic logic [MND_W-1:0] n_total(input logic [MND_W-1:0] m,
                                               input logic [MND_W-1:0] nreg);
    return m + ~nreg;
  endfunction

  function automatic logic [MND_W-1:0] acc_step(input logic [MND_W-1:0] acc,
                                                input logic [MND_W-1:0] m,
                                                input logic [MND_W-1:0] n);
    logic [MND_W:0] s;
    s = {1'b0, acc} + {1'b0, m};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[MND_W-1:0];
  endfunction

  rcg_cfg_t         act_cfg;
  logic [MND_W-1:0] act_m, act_n, act_d;
  logic [5:0]       cnt_q, cnt_nx, cmax;
  logic [MND_W-1:0] acc_q, acc_nx, two_d;
  logic             out_q, sel_edge, absent, pd_wrap, mnd_on, mnd_level;

  always_comb begin
    sel_edge = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if ({1'b0, act_cfg.src} == 4'(i)) sel_edge = src_edge[i];
  end

  assign absent    = {1'b0, act_cfg.src} >= NSRC_L;
  assign cmax      = half_max(act_cfg.code);
  assign pd_wrap   = sel_edge && (cnt_q == cmax);
  assign cnt_nx    = pd_wrap ? 6'd0 : cnt_q + 6'd1;
  assign mnd_on    = (act_cfg.mode == MODE_MND);
  assign acc_nx    = acc_step(acc_q, act_m, n_total(act_m, act_n));
  assign two_d     = ~act_d;
  assign mnd_level = {acc_nx, 1'b0} < {1'b0, two_d};
  assign commit    = pending && ((pd_wrap && !out_q) || absent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cfg <= '0;
      act_m   <= '0;
      act_n   <= '0;
      act_d   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      out_q   <= 1'b0;
    end else if (commit) begin
      act_cfg <= sh_cfg;
      act_m   <= sh_m;
      act_n   <= sh_n;
      act_d   <= sh_d;
      cnt_q   <= '0;
      acc_q   <= '0;
      out_q   <= 1'b0;
    end else if (sel_edge) begin
      cnt_q <= cnt_nx;
      if (mnd_on) begin
        if (pd_wrap) begin
          acc_q <= acc_nx;
          out_q <= mnd_level;
        end
      end else begin
        out_q <= (cnt_nx < high_len(cmax));
      end
    end
  end

  assign clk_out = out_q;

  AST_COMMIT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !out_q); // R8
  AST_COMMIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> pending); // R3
  AST_QUIET_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_edge && !commit) |=> $stable(out_q)); // R4
  AST_ABSENT_SRC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    absent |=> !out_q); // R5
  AST_MND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mnd_on && !pd_wrap && !commit) |=> $stable(out_q)); // R7
  AST_AFTER_COMMIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt_q == 6'd0) && (acc_q == '0) && !out_q); // R8
endmodule

// File: rtl/root_clk_gen.sv
module root_clk_gen
  import rcg_pkg::*;
#(
  parameter int NSRC   = 2,
  parameter int DATA_W = 32,
  parameter int MND_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   src_clk,
  output logic              clk_out
);
  logic             pending, commit;
  rcg_cfg_t         sh_cfg;
  logic [MND_W-1:0] sh_m, sh_n, sh_d;
  logic [NSRC-1:0]  src_edge;

  rcg_regfile #(.DATA_W(DATA_W), .MND_W(MND_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .commit  (commit),
    .rdata   (reg_rdata),
    .pending (pending),
    .sh_cfg  (sh_cfg),
    .sh_m    (sh_m),
    .sh_n    (sh_n),
    .sh_d    (sh_d)
  );

  rcg_src_sync #(.NSRC(NSRC), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_clk  (src_clk),
    .src_edge (src_edge)
  );

  rcg_div_core #(.NSRC(NSRC), .MND_W(MND_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_edge (src_edge),
    .pending  (pending),
    .sh_cfg   (sh_cfg),
    .sh_m     (sh_m),
    .sh_n     (sh_n),
    .sh_d     (sh_d),
    .commit   (commit),
    .clk_out  (clk_out)
  );
endmodule

// File: tb/root_clk_gen_test.sv
`timescale 1ns/1ps
module root_clk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s0 = 1'b0, s1 = 1'b0;
  logic        clk_out;
  int checks = 0, fails = 0;
  bit done = 0;

  root_clk_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_clk({s1, s0}),
    .clk_out(clk_out)
  );

  always #2 clk = ~clk;
  // source 0: 5 clk cycles per half-period, source 1: 3
  initial begin #1; forever #20 s0 = ~s0; end
  initial begin #1; forever #12 s1 = ~s1; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  // request an update, check it is pending, wait for it to be taken
  task automatic do_update(input string req);
    int n;
    wr(3'd0, 32'h0);
    chk(reg_rdata[0] == 1'b0, "R3 zero write", int'(reg_rdata[0]), 0);
    wr(3'd0, 32'h1);
    chk(reg_rdata[0] == 1'b1, "R3 pending", int'(reg_rdata[0]), 1);
    n = 0;
    while (reg_rdata[0] && n < 3000) begin @(negedge clk); n++; end
    chk(reg_rdata[0] == 1'b0, {req, " update taken"}, int'(reg_rdata[0]), 0);
    chk(clk_out == 1'b0, "R8 low after update", int'(clk_out), 0);
  endtask

  task automatic wait_rise(output bit ok);
    logic prev;
    int n;
    prev = clk_out; n = 0; ok = 0;
    while (n < 3000 && !ok) begin
      @(negedge clk); n++;
      if (!prev && clk_out) ok = 1;
      prev = clk_out;
    end
  endtask

  task automatic measure(output int per, output int hi);
    bit ok;
    int h, l;
    for (int k = 0; k < 3; k++) wait_rise(ok);
    per = -1; hi = -1;
    if (!ok) return;
    h = 0; l = 0;
    while (clk_out && h < 3000) begin @(negedge clk); h++; end
    while (!clk_out && l < 3000) begin @(negedge clk); l++; end
    hi = h; per = h + l;
  endtask

  task automatic expect_shape(input string req, input int per_e, input int hi_e);
    int per, hi;
    measure(per, hi);
    chk(per == per_e, {req, " period"}, per, per_e);
    chk(hi == hi_e, {req, " high time"}, hi, hi_e);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(clk_out == 1'b0, "R1 out low", int'(clk_out), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 32'h0, "R1 reg zero", int'(d), 0);
    end
    expect_shape("R1 R6 bypass", 10, 5);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk(d == 32'h3FFF, "R2 cfg mask", int'(d), 32'h3FFF);
    wr(3'd2, 32'h0000_01A5);
    rd(3'd2, d); chk(d == 32'hA5, "R2 M mask", int'(d), 32'hA5);
    wr(3'd3, 32'hFFFF_FF12);
    rd(3'd3, d); chk(d == 32'h12, "R2 N mask", int'(d), 32'h12);
    wr(3'd4, 32'h0000_0133);
    rd(3'd4, d); chk(d == 32'h33, "R2 D mask", int'(d), 32'h33);
    // shadow now selects an absent source; output must not notice (R4)
    expect_shape("R4 shadow only", 10, 5);
    wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
  endtask

  task automatic t_prediv();
    wr(3'd1, 32'h0000_0003);
    do_update("R6");
    expect_shape("R6 div2", 20, 10);
    wr(3'd1, 32'h0000_0004);
    do_update("R6");
    expect_shape("R6 div2.5", 25, 15);
    wr(3'd1, 32'h0000_1003); // mode 1 is not the fractional mode
    do_update("R7");
    expect_shape("R7 mode1 plain", 20, 10);
  endtask

  task automatic t_source();
    wr(3'd1, 32'h0000_0101);
    do_update("R5");
    expect_shape("R5 src1", 6, 3);
    wr(3'd1, 32'h0000_0102);
    do_update("R5");
    expect_shape("R5 src1 div1.5", 9, 6);
  endtask

  task automatic t_mnd_half();
    wr(3'd2, 32'h01);
    wr(3'd3, 32'hFC); // ~(4-1)
    wr(3'd4, 32'hFB); // ~4
    wr(3'd1, 32'h0000_2001);
    do_update("R7");
    expect_shape("R9 R7 50pct", 40, 20);
  endtask

  task automatic t_mnd_frac();
    bit ok;
    int rises;
    logic prev;
    wr(3'd2, 32'h02);
    wr(3'd3, 32'hFC); // ~(5-2)
    wr(3'd4, 32'hFA); // ~5
    do_update("R7");
    for (int k = 0; k < 3; k++) wait_rise(ok);
    rises = 0; prev = clk_out;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (!prev && clk_out) rises++;
      prev = clk_out;
    end
    chk(rises == 8, "R10 rises per window", rises, 8);
  endtask

  task automatic t_absent();
    int highs;
    wr(3'd1, 32'h0000_0501);
    do_update("R5");
    highs = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    chk(highs == 0, "R5 absent source low", highs, 0);
    wr(3'd1, 32'h0000_0001);
    do_update("R5 escape");
    expect_shape("R5 back to src0", 10, 5);
  endtask

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_prediv();
    t_source();
    t_mnd_half();
    t_mnd_frac();
    t_absent();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule